// File: doc/BRIEF.md
# Dual-Processor Shared Memory Region Arbiter

This block sits between two processors and three shared memory regions: a read-only program store (ROM), a battery-backed work RAM of up to 256 KB, and a fixed 2 KB internal RAM. The host processor is slow. The coprocessor runs off the same base clock `clk`, and `clk` runs four times faster than the host's access rate. The block divides time into frames of four `clk` cycles. The host owns the first cycle of each frame, called the host slot. The coprocessor may issue one access in every cycle.

Both address ports carry a 24-bit bank:offset address, and one shared decoder maps that address to a region and a local offset. If both processors want the same region in the host slot, the host wins. The coprocessor then sees `c_rdy` low for that one cycle and completes its access in the next cycle. Accesses to two different regions run in the same cycle. A saturating counter for each region counts the cycles in which such a collision occurred.

The host's read data is captured at the end of its slot and held until its next read, so the slow host may sample it at any time. Coprocessor read data is returned in the same cycle as the grant.

Top module: `shmem_region_arb`

## Requirements
- R1: `h_slot` is high in the first cycle after reset and then in exactly one cycle of every four.
- R2: Address decode works as follows, where "low banks" means banks whose bit 6 is 0:
  - Banks C0-FF go to ROM at offset addr[21:0].
  - In the low banks, offsets 8000-FFFF go to ROM at offset {bank[5:0], addr[14:0]}.
  - Banks 40-43 go to work RAM at offset addr[17:0].
  - In the low banks, offsets 6000-7FFF go to work RAM at offset addr[12:0].
  - In the low banks, offsets 3000-37FF go to internal RAM at offset addr[10:0].
  - Every other address is undecoded.
- R3: When the host (in its slot) and the coprocessor target different decoded regions, both region ports are enabled in the same cycle and `c_rdy` stays high.
- R4: When both target the same region in the host slot, the region port carries the host's address and data, and `c_rdy` is low for that cycle only.
- R5: A host read in its slot loads `h_rdata` at the closing clock edge with the region's read data, or with zero if the address is undecoded. `h_rdata` holds its value at every other edge.
- R6: A coprocessor request to an undecoded address never stalls, returns `c_rdata` = 0 and enables no region. This includes the host-only areas: banks 7E/7F and low-bank offsets 0000-1FFF, 2xxx and 4xxx.
- R7: Each region has a collision counter. It adds one for each cycle in which the host slot and the coprocessor collide on that region, and it saturates at 2^CNT_W-1.
- R8: A granted coprocessor read returns the region's read data in the same cycle; otherwise `c_rdata` is 0. Writes drive `*_we` and `*_wdata` from the owner on work RAM and internal RAM. A write to ROM enables nothing.
- R9: While reset is held, `h_rdata` and all collision counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, four times the host access rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write enable |
| h_addr | input | 24 | Host bank:offset address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, held between slots |
| h_slot | output | 1 | High in the host's cycle of each frame |
| c_req | input | 1 | Coprocessor access request |
| c_we | input | 1 | Coprocessor write enable |
| c_addr | input | 24 | Coprocessor bank:offset address |
| c_wdata | input | DW | Coprocessor write data |
| c_rdata | output | DW | Coprocessor read data, same cycle |
| c_rdy | output | 1 | Low when the coprocessor access is stalled |
| rom_en | output | 1 | ROM read strobe |
| rom_addr | output | 22 | ROM local offset |
| rom_rdata | input | DW | ROM read data |
| wram_en | output | 1 | Work RAM strobe |
| wram_we | output | 1 | Work RAM write enable |
| wram_addr | output | 18 | Work RAM local offset |
| wram_wdata | output | DW | Work RAM write data |
| wram_rdata | input | DW | Work RAM read data |
| iram_en | output | 1 | Internal RAM strobe |
| iram_we | output | 1 | Internal RAM write enable |
| iram_addr | output | 11 | Internal RAM local offset |
| iram_wdata | output | DW | Internal RAM write data |
| iram_rdata | input | DW | Internal RAM read data |
| coll_rom_cnt | output | CNT_W | ROM collision count |
| coll_wram_cnt | output | CNT_W | Work RAM collision count |
| coll_iram_cnt | output | CNT_W | Internal RAM collision count |

## Verification
The assertions check four things on every cycle:
- the one-in-four slot rhythm;
- that a stall only occurs inside the host slot and never lasts two cycles;
- that undecoded coprocessor requests stay free and return zero;
- that host read data holds outside the slot, and that the counters step by one and stick at their maximum.

Only the bench scenarios can show the rest:
- that the decode map lands each address on the right region and offset;
- that the host's address and data win a collided region;
- that parallel access to different regions goes through;
- that ROM writes are dropped;
- that the counter values match the collisions actually driven.

// File: rtl/shmem_arb_pkg.sv
package shmem_arb_pkg;
    localparam int ADDR_W  = 24;
    localparam int ROM_AW  = 22;
    localparam int WRAM_AW = 18;
    localparam int IRAM_AW = 11;
    localparam int OFF_W   = ROM_AW;
    localparam int NUM_RGN = 3;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_ROM  = 2'd1,
        RGN_WRAM = 2'd2,
        RGN_IRAM = 2'd3
    } rgn_e;
endpackage

// File: rtl/shmem_addr_dec.sv
module shmem_addr_dec
    import shmem_arb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rgn,
    output logic [OFF_W-1:0]  off
);
    logic [7:0]  bank;
    logic [15:0] ofs;
    logic        low_bank;

    assign bank     = addr[23:16];
    assign ofs      = addr[15:0];
    assign low_bank = !bank[6];

    always_comb begin
        rgn = RGN_NONE;
        off = '0;
        if (bank[7:6] == 2'b11) begin
            rgn = RGN_ROM;
            off = addr[OFF_W-1:0];
        end else if (low_bank && ofs[15]) begin
            rgn = RGN_ROM;
            off = {1'b0, bank[5:0], ofs[14:0]};
        end else if (bank[7:2] == 6'b010000) begin
            rgn = RGN_WRAM;
            off = {{(OFF_W-WRAM_AW){1'b0}}, addr[WRAM_AW-1:0]};
        end else if (low_bank && ofs[15:13] == 3'b011) begin
            rgn = RGN_WRAM;
            off = {{(OFF_W-13){1'b0}}, ofs[12:0]};
        end else if (low_bank && ofs[15:11] == 5'b00110) begin
            rgn = RGN_IRAM;
            off = {{(OFF_W-IRAM_AW){1'b0}}, ofs[IRAM_AW-1:0]};
        end
    end
endmodule

// File: rtl/shmem_slot_gen.sv
module shmem_slot_gen #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot
);
    localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign slot = (phase_q == '0);

    AST_SLOT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == LAST) |=> slot);   // R1
    AST_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        slot |=> !slot);               // R1
endmodule

// File: rtl/shmem_coll_ctr.sv
module shmem_coll_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hit && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    AST_CNT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));                 // R7
    AST_CNT_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R7
endmodule

// File: rtl/shmem_region_arb.sv
module shmem_region_arb
    import shmem_arb_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CNT_W = 8,
    parameter int RATIO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_req,
    input  logic               h_we,
    input  logic [ADDR_W-1:0]  h_addr,
    input  logic [DW-1:0]      h_wdata,
    output logic [DW-1:0]      h_rdata,
    output logic               h_slot,
    input  logic               c_req,
    input  logic               c_we,
    input  logic [ADDR_W-1:0]  c_addr,
    input  logic [DW-1:0]      c_wdata,
    output logic [DW-1:0]      c_rdata,
    output logic               c_rdy,
    output logic               rom_en,
    output logic [ROM_AW-1:0]  rom_addr,
    input  logic [DW-1:0]      rom_rdata,
    output logic               wram_en,
    output logic               wram_we,
    output logic [WRAM_AW-1:0] wram_addr,
    output logic [DW-1:0]      wram_wdata,
    input  logic [DW-1:0]      wram_rdata,
    output logic               iram_en,
    output logic               iram_we,
    output logic [IRAM_AW-1:0] iram_addr,
    output logic [DW-1:0]      iram_wdata,
    input  logic [DW-1:0]      iram_rdata,
    output logic [CNT_W-1:0]   coll_rom_cnt,
    output logic [CNT_W-1:0]   coll_wram_cnt,
    output logic [CNT_W-1:0]   coll_iram_cnt
);
    typedef struct packed {
        logic [DW-1:0] h_rdata;
    } state_t;

    rgn_e             h_rgn, c_rgn;
    logic [OFF_W-1:0] h_off, c_off;
    logic             h_act, c_act, collide;
    logic [NUM_RGN-1:0] h_own, c_hit, c_own, r_en, r_we;
    logic [CNT_W-1:0] cnt [NUM_RGN];
    state_t           st_d, st_q;

    shmem_addr_dec u_hdec (.addr(h_addr), .rgn(h_rgn), .off(h_off));
    shmem_addr_dec u_cdec (.addr(c_addr), .rgn(c_rgn), .off(c_off));

    shmem_slot_gen #(.RATIO(RATIO)) u_slot (.clk(clk), .rst_n(rst_n), .slot(h_slot));

    assign h_act = h_slot && h_req && (h_rgn != RGN_NONE);
    assign c_act = c_req && (c_rgn != RGN_NONE);

    for (genvar gi = 0; gi < NUM_RGN; gi++) begin : g_rgn
        localparam rgn_e RG       = rgn_e'(gi + 1);
        localparam bit   WRITABLE = (gi != 0);

        assign h_own[gi] = h_act && (h_rgn == RG);
        assign c_hit[gi] = c_act && (c_rgn == RG);
        assign c_own[gi] = c_hit[gi] && !h_own[gi];
        assign r_en[gi]  = h_own[gi] ? (WRITABLE || !h_we)
                                     : (c_own[gi] && (WRITABLE || !c_we));
        assign r_we[gi]  = WRITABLE && (h_own[gi] ? h_we : (c_own[gi] && c_we));

        shmem_coll_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n),
            .hit(h_own[gi] && c_hit[gi]),
            .count(cnt[gi])
        );
    end

    assign collide = |(h_own & c_hit);
    assign c_rdy   = !collide;

    assign rom_en     = r_en[0];
    assign rom_addr   = h_own[0] ? h_off : c_off;
    assign wram_en    = r_en[1];
    assign wram_we    = r_we[1];
    assign wram_addr  = h_own[1] ? h_off[WRAM_AW-1:0] : c_off[WRAM_AW-1:0];
    assign wram_wdata = h_own[1] ? h_wdata : c_wdata;
    assign iram_en    = r_en[2];
    assign iram_we    = r_we[2];
    assign iram_addr  = h_own[2] ? h_off[IRAM_AW-1:0] : c_off[IRAM_AW-1:0];
    assign iram_wdata = h_own[2] ? h_wdata : c_wdata;

    assign coll_rom_cnt  = cnt[0];
    assign coll_wram_cnt = cnt[1];
    assign coll_iram_cnt = cnt[2];

    always_comb begin
        c_rdata = '0;
        if (c_act && !collide && !c_we) begin
            case (c_rgn)
                RGN_ROM:  c_rdata = rom_rdata;
                RGN_WRAM: c_rdata = wram_rdata;
                RGN_IRAM: c_rdata = iram_rdata;
                default:  c_rdata = '0;
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        if (h_slot && h_req && !h_we) begin
            case (h_rgn)
                RGN_ROM:  st_d.h_rdata = rom_rdata;
                RGN_WRAM: st_d.h_rdata = wram_rdata;
                RGN_IRAM: st_d.h_rdata = iram_rdata;
                default:  st_d.h_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_rdata = st_q.h_rdata;

    AST_STALL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !c_rdy |-> h_slot);                                         // R4
    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !c_rdy |=> c_rdy);                                          // R4
    AST_SPLIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (h_act && c_act && h_rgn != c_rgn) |-> c_rdy);              // R3
    AST_UNDECODED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && c_rgn == RGN_NONE) |-> (c_rdy && c_rdata == '0)); // R6
    AST_HRDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(h_slot) |-> $stable(h_rdata));                       // R5
endmodule

// File: tb/shmem_region_arb_tb_top.sv
`timescale 1ns/1ps
module shmem_region_arb_tb_top;
    localparam int DW = 8;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_req = 0, h_we = 0, c_req = 0, c_we = 0;
    logic [23:0] h_addr = '0, c_addr = '0;
    logic [DW-1:0] h_wdata = '0, c_wdata = '0;
    logic [DW-1:0] h_rdata, c_rdata;
    logic h_slot, c_rdy;
    logic rom_en, wram_en, wram_we, iram_en, iram_we;
    logic [21:0] rom_addr;
    logic [17:0] wram_addr;
    logic [10:0] iram_addr;
    logic [DW-1:0] rom_rdata, wram_rdata, iram_rdata, wram_wdata, iram_wdata;
    logic [CW-1:0] c_rom, c_wram, c_iram;

    int checks = 0;
    int errors = 0;
    int ph = 0;
    logic [DW-1:0] exp_hrd = '0;
    int exp_cnt [4];

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_val(input int r, input logic [21:0] a);
        case (r)
            1: return a[7:0] ^ a[15:8] ^ 8'h5A;
            2: return a[7:0] + {a[17:12], 2'b01};
            3: return ~a[7:0] ^ {a[10:8], 5'b0};
            default: return 8'h00;
        endcase
    endfunction

    assign rom_rdata  = mem_val(1, rom_addr);
    assign wram_rdata = mem_val(2, {4'b0, wram_addr});
    assign iram_rdata = mem_val(3, {11'b0, iram_addr});

    shmem_region_arb #(.DW(DW), .CNT_W(CW), .RATIO(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_slot(h_slot),
        .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_rdata(c_rdata), .c_rdy(c_rdy),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .wram_en(wram_en), .wram_we(wram_we), .wram_addr(wram_addr),
        .wram_wdata(wram_wdata), .wram_rdata(wram_rdata),
        .iram_en(iram_en), .iram_we(iram_we), .iram_addr(iram_addr),
        .iram_wdata(iram_wdata), .iram_rdata(iram_rdata),
        .coll_rom_cnt(c_rom), .coll_wram_cnt(c_wram), .coll_iram_cnt(c_iram)
    );

    // R2 decode model: 0 none, 1 ROM, 2 work RAM, 3 internal RAM
    function automatic int dec_rgn(input logic [23:0] a);
        logic lo;
        lo = !a[22];
        if (a[23:22] == 2'b11) return 1;
        if (lo && a[15]) return 1;
        if (a[23:18] == 6'b010000) return 2;
        if (lo && a[15:13] == 3'b011) return 2;
        if (lo && a[15:11] == 5'b00110) return 3;
        return 0;
    endfunction

    function automatic logic [21:0] dec_off(input logic [23:0] a);
        case (dec_rgn(a))
            1: return (a[23:22] == 2'b11) ? a[21:0] : {1'b0, a[21:16], a[14:0]};
            2: return (a[23:18] == 6'b010000) ? {4'b0, a[17:0]} : {9'b0, a[12:0]};
            3: return {11'b0, a[10:0]};
            default: return 22'd0;
        endcase
    endfunction

    function automatic logic [23:0] rnd_addr(input int k);
        logic [7:0] lob;
        lob = {1'($urandom_range(0, 1)), 1'b0, 6'($urandom_range(0, 63))};
        case (k)
            0: return {2'b11, 22'($urandom)};
            1: return {lob, 1'b1, 15'($urandom)};
            2: return {6'b010000, 18'($urandom)};
            3: return {lob, 3'b011, 13'($urandom)};
            4: return {lob, 5'b00110, 11'($urandom)};
            5: return {7'b0111111, 1'($urandom), 16'($urandom)};
            6: return {lob, ($urandom_range(0, 1) != 0) ? 4'h2 : 4'h4, 12'($urandom)};
            default: return {lob, 3'b000, 13'($urandom)};
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_regs();
        chk(32'(h_rdata), 32'(exp_hrd), "R5 h_rdata");
        chk(32'(c_rom),  32'(exp_cnt[1]), "R7 rom count");
        chk(32'(c_wram), 32'(exp_cnt[2]), "R7 wram count");
        chk(32'(c_iram), 32'(exp_cnt[3]), "R7 iram count");
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic hq, input logic hw, input logic [23:0] ha, input logic [7:0] hd,
                        input logic cq, input logic cw, input logic [23:0] ca, input logic [7:0] cd);
        int hr, cr, own;
        bit slot, hact, cact, col;
        logic [21:0] ho, co;
        string tg;
        chk_regs();
        h_req = hq; h_we = hw; h_addr = ha; h_wdata = hd;
        c_req = cq; c_we = cw; c_addr = ca; c_wdata = cd;
        #0.5;
        slot = (ph == 0);
        hr = dec_rgn(ha); ho = dec_off(ha);
        cr = dec_rgn(ca); co = dec_off(ca);
        hact = slot && hq && hr != 0;
        cact = cq && cr != 0;
        col  = hact && cact && hr == cr;
        chk(32'(h_slot), 32'(slot), "R1 h_slot");
        tg = col ? "R4 c_rdy" : (hact && cact) ? "R3 c_rdy" : (cq && cr == 0) ? "R6 c_rdy" : "R8 c_rdy";
        chk(32'(c_rdy), 32'(!col), tg);
        chk(32'(c_rdata), (cact && !col && !cw) ? 32'(mem_val(cr, co)) : 32'd0,
            (cq && cr == 0) ? "R6 c_rdata" : "R8 c_rdata");
        for (int r = 1; r <= 3; r++) begin
            logic en, we, exp_en, exp_we;
            logic [21:0] ad, exp_ad;
            logic [7:0] wd, exp_wd;
            own = (hact && hr == r) ? 1 : (cact && cr == r) ? 2 : 0;
            exp_we = (r != 1) && ((own == 1) ? hw : (own == 2) ? cw : 1'b0);
            exp_en = (own == 1) ? (r != 1 || !hw) : (own == 2) ? (r != 1 || !cw) : 1'b0;
            exp_ad = (own == 1) ? ho : co;
            exp_wd = (own == 1) ? hd : cd;
            case (r)
                1: begin en = rom_en; we = 1'b0; ad = rom_addr; wd = exp_wd; end
                2: begin en = wram_en; we = wram_we; ad = {4'b0, wram_addr}; wd = wram_wdata; end
                default: begin en = iram_en; we = iram_we; ad = {11'b0, iram_addr}; wd = iram_wdata; end
            endcase
            chk(32'(en), 32'(exp_en), (own == 0) ? "R6 region idle" : "R2 region enable");
            if (exp_en) begin
                chk(32'(ad), 32'(exp_ad), col ? "R4 owner addr" : "R2 region offset");
                chk(32'(we), 32'(exp_we), "R8 write enable");
                if (exp_we) chk(32'(wd), 32'(exp_wd), col ? "R4 owner wdata" : "R8 wdata");
            end
        end
        if (slot && hq && !hw) exp_hrd = (hr == 0) ? 8'h00 : mem_val(hr, ho);
        if (col && exp_cnt[hr] < 255) exp_cnt[hr]++;
        ph = (ph + 1) % 4;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = $urandom(32'h5EED_0A11);
        for (int i = 0; i < 4; i++) exp_cnt[i] = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(32'(h_rdata), 32'd0, "R9 h_rdata in reset");
        chk(32'(c_rom), 32'd0, "R9 rom count in reset");
        chk(32'(c_wram), 32'd0, "R9 wram count in reset");
        chk(32'(c_iram), 32'd0, "R9 iram count in reset");
        rst_n = 1'b1;
        ph = 0;
        // R4 collision on internal RAM, host writes; coprocessor retries next cycle
        step(1, 1, 24'h003010, 8'hC3, 1, 1, 24'h803022, 8'h3C);
        step(0, 0, 24'h0, 8'h0, 1, 1, 24'h803022, 8'h3C);
        step(0, 0, 24'h0, 8'h0, 0, 0, 24'h0, 8'h0);
        step(0, 0, 24'h0, 8'h0, 0, 0, 24'h0, 8'h0);
        // R3 parallel ROM and work RAM in the slot
        step(1, 0, 24'hC12345, 8'h0, 1, 0, 24'h416789, 8'h0);
        // R6 host-only spaces from the coprocessor
        step(0, 0, 24'h0, 8'h0, 1, 0, 24'h7E1234, 8'h0);
        step(0, 0, 24'h0, 8'h0, 1, 0, 24'h002100, 8'h0);
        step(0, 0, 24'h0, 8'h0, 1, 1, 24'h004200, 8'h11);
        // R5 undecoded host read clears h_rdata; R8 ROM write dropped
        step(1, 0, 24'h7F0000, 8'h0, 1, 1, 24'hC00000, 8'hAA);
        step(0, 0, 24'h0, 8'h0, 1, 0, 24'h3FFFFF, 8'h0);
        step(0, 0, 24'h0, 8'h0, 0, 0, 24'h0, 8'h0);
        step(0, 0, 24'h0, 8'h0, 0, 0, 24'h0, 8'h0);
        // R4 host write to ROM still owns the region
        step(1, 1, 24'h008000, 8'h55, 1, 0, 24'hFF0001, 8'h0);
        repeat (3) step(0, 0, 24'h0, 8'h0, 0, 0, 24'h0, 8'h0);
        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            int kh, kc;
            kh = $urandom_range(0, 7);
            kc = ($urandom_range(0, 2) == 0) ? kh : $urandom_range(0, 7);
            step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) == 0),
                 rnd_addr(kh), 8'($urandom),
                 1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 2) == 0),
                 rnd_addr(kc), 8'($urandom));
        end
        // R7 saturation on internal RAM
        for (int n = 0; n < 1100; n++)
            step(1, 0, 24'h003000, 8'h0, 1, 0, 24'h0037FF, 8'h0);
        chk(32'(c_iram), 32'd255, "R7 saturated");
        chk_regs();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule